// File: doc/BRIEF.md
# Load/Store Memory Ordering Checker

This block holds memory accesses of a decoupled integer/floating-point machine between address generation and the data cache. It takes the place of a load reservation station. Loads wait in a load queue and leave it strictly in fetch order. Stores wait in a store queue and may leave in any order once they are safe. Every access carries a wrapping 4-bit sequence tag that gives its program age. An access whose address is not yet known can be entered early, and its address is filled in later through an update port that names its slot.

Each entry checks its ordering against every older entry in the other queue, and stores also check against older stores. A load waits while an older store may write the same word (read-after-write). A store waits while an older load may read the same word (write-after-read), or while an older store may write it (write-after-write). An older entry whose address is still unknown counts as a conflict. Per-slot hazard flags show which entries are blocked. One load and one store can be offered for issue each cycle, and each is accepted with a ready/valid handshake.

Top module: `lsq_order_check`

## Requirements
- R1: After reset both queues are empty: `ld_enq_ready` and `st_enq_ready` are 1, both issue valids are 0, all hazard flags are 0, and `ld_enq_slot` and `st_enq_slot` are 0.
- R2: The load queue holds 4 entries. `ld_enq_ready` is 0 while it is full, and a load enqueue attempted while full is dropped: it never appears at the issue port.
- R3: Only the oldest load in the queue (the head, whose slot is shown on `ld_issue_slot`) can be offered. A younger, unblocked load waits while the head has no address or is blocked. Loads leave in the order they were enqueued.
- R4: A load whose address matches an older pending store has its `ld_hazard` bit set and is not offered. Once that store leaves, the load is offered.
- R5: An older store whose address is not yet valid blocks every younger load.
- R6: A store is blocked (its `st_hazard` bit is set, and it is not offered) by an older pending load to the same word, or by an older load whose address is unknown.
- R7: A store is blocked by an older pending store to the same word, or by an older store whose address is unknown.
- R8: Addresses are compared at word granularity: bits [1:0] are ignored. Addresses that differ only in those bits conflict. Addresses that differ in any higher bit do not.
- R9: Only older entries take part. Tag a is older than tag b when (b − a) mod 16 lies in 1..7, so tag 15 is older than tag 1. A younger store to the same word does not block a load.
- R10: An update on `ld_upd_*` or `st_upd_*` marks the named slot's address as valid with the given value. Hazards are then evaluated against the new address from the next cycle on.
- R11: The store queue holds 4 entries and fills the lowest free slot, shown on `st_enq_slot`. Among eligible stores, the lowest slot index is offered. `st_enq_ready` is 0 when all 4 slots are used.
- R12: An offered access leaves its queue on the clock edge where both its issue valid and its issue ready are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_enq_valid | input | 1 | Enter a load |
| ld_enq_addr_valid | input | 1 | Address of the entered load is known |
| ld_enq_addr | input | 32 | Load byte address |
| ld_enq_tag | input | 4 | Load sequence tag |
| ld_enq_ready | output | 1 | Load queue has room |
| ld_enq_slot | output | 2 | Slot the next load will take |
| st_enq_valid | input | 1 | Enter a store |
| st_enq_addr_valid | input | 1 | Address of the entered store is known |
| st_enq_addr | input | 32 | Store byte address |
| st_enq_tag | input | 4 | Store sequence tag |
| st_enq_ready | output | 1 | Store queue has room |
| st_enq_slot | output | 2 | Slot the next store will take |
| ld_upd_valid | input | 1 | Supply a load address |
| ld_upd_slot | input | 2 | Load slot being updated |
| ld_upd_addr | input | 32 | Late load address |
| st_upd_valid | input | 1 | Supply a store address |
| st_upd_slot | input | 2 | Store slot being updated |
| st_upd_addr | input | 32 | Late store address |
| ld_issue_valid | output | 1 | Head load may proceed |
| ld_issue_ready | input | 1 | Consumer takes the load |
| ld_issue_slot | output | 2 | Head load slot |
| ld_issue_addr | output | 32 | Offered load address |
| ld_issue_tag | output | 4 | Offered load tag |
| st_issue_valid | output | 1 | A store may proceed |
| st_issue_ready | input | 1 | Consumer takes the store |
| st_issue_slot | output | 2 | Offered store slot |
| st_issue_addr | output | 32 | Offered store address |
| st_issue_tag | output | 4 | Offered store tag |
| ld_hazard | output | 4 | Per load slot: blocked by an older store |
| st_hazard | output | 4 | Per store slot: blocked by an older load or store |

## Verification
The bench pairs loads and stores to the same word in both age orders. A checker that compared ages the wrong way would block a load behind a younger store, or let it pass an older one. It uses addresses inside one word and in neighbouring words: a byte-granular compare would miss the 0x300/0x303 conflict, and a compare on too few bits would flag the 0x400/0x404 pair. It also covers tags that wrap from 15 to 1, unknown addresses filled in later, a blocked head with a ready load behind it (which would escape under out-of-order load issue), and enqueue into a full load queue, which must drop the new entry rather than overwrite the oldest.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    localparam int ADDR_W   = 32;
    localparam int TAG_W    = 4;
    localparam int WORD_LSB = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  valid;
        logic  addr_ok;
        addr_t addr;
        tag_t  tag;
    } slot_t;

    // a precedes b in program order (window of half the tag space)
    function automatic logic is_older(tag_t a, tag_t b);
        tag_t diff;
        diff = b - a;
        return (diff != '0) && !diff[TAG_W-1];
    endfunction

    function automatic logic same_word(addr_t a, addr_t b);
        return a[ADDR_W-1:WORD_LSB] == b[ADDR_W-1:WORD_LSB];
    endfunction

endpackage

// File: rtl/lsq_pick_first.sv
module lsq_pick_first #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                found = 1'b1;
                idx   = k[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/lsq_hazard_matrix.sv
module lsq_hazard_matrix
    import lsq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  slot_t [DEPTH-1:0] ldq,
    input  slot_t [DEPTH-1:0] stq,
    output logic  [DEPTH-1:0] ld_block,
    output logic  [DEPTH-1:0] st_block
);
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
        logic [DEPTH-1:0] raw_v;
        logic [DEPTH-1:0] war_v;
        logic [DEPTH-1:0] waw_v;

        always_comb begin
            for (int j = 0; j < DEPTH; j++) begin
                // load gi against store j
                raw_v[j] = ldq[gi].valid && stq[j].valid
                        && is_older(stq[j].tag, ldq[gi].tag)
                        && (!stq[j].addr_ok
                            || (ldq[gi].addr_ok && same_word(stq[j].addr, ldq[gi].addr)));
                // store gi against load j
                war_v[j] = stq[gi].valid && ldq[j].valid
                        && is_older(ldq[j].tag, stq[gi].tag)
                        && (!ldq[j].addr_ok
                            || (stq[gi].addr_ok && same_word(ldq[j].addr, stq[gi].addr)));
                // store gi against store j
                waw_v[j] = stq[gi].valid && stq[j].valid
                        && is_older(stq[j].tag, stq[gi].tag)
                        && (!stq[j].addr_ok
                            || (stq[gi].addr_ok && same_word(stq[j].addr, stq[gi].addr)));
            end
        end

        assign ld_block[gi] = |raw_v;
        assign st_block[gi] = |(war_v | waw_v);
    end
endmodule

// File: rtl/lsq_order_check.sv
module lsq_order_check
    import lsq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = ADDR_W,
    parameter int TW    = TAG_W,
    parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_enq_valid,
    input  logic          ld_enq_addr_valid,
    input  logic [AW-1:0] ld_enq_addr,
    input  logic [TW-1:0] ld_enq_tag,
    output logic          ld_enq_ready,
    output logic [IW-1:0] ld_enq_slot,
    input  logic          st_enq_valid,
    input  logic          st_enq_addr_valid,
    input  logic [AW-1:0] st_enq_addr,
    input  logic [TW-1:0] st_enq_tag,
    output logic          st_enq_ready,
    output logic [IW-1:0] st_enq_slot,
    input  logic          ld_upd_valid,
    input  logic [IW-1:0] ld_upd_slot,
    input  logic [AW-1:0] ld_upd_addr,
    input  logic          st_upd_valid,
    input  logic [IW-1:0] st_upd_slot,
    input  logic [AW-1:0] st_upd_addr,
    output logic          ld_issue_valid,
    input  logic          ld_issue_ready,
    output logic [IW-1:0] ld_issue_slot,
    output logic [AW-1:0] ld_issue_addr,
    output logic [TW-1:0] ld_issue_tag,
    output logic          st_issue_valid,
    input  logic          st_issue_ready,
    output logic [IW-1:0] st_issue_slot,
    output logic [AW-1:0] st_issue_addr,
    output logic [TW-1:0] st_issue_tag,
    output logic [DEPTH-1:0] ld_hazard,
    output logic [DEPTH-1:0] st_hazard
);
    localparam int CW = IW + 1;

    typedef struct packed {
        slot_t [DEPTH-1:0] lq;
        slot_t [DEPTH-1:0] sq;
        logic  [IW-1:0]    ld_head;
        logic  [IW-1:0]    ld_tail;
        logic  [CW-1:0]    ld_count;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [IW-1:0] bump(logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [DEPTH-1:0] ld_block, st_block;
    logic [DEPTH-1:0] st_free, st_elig;
    logic             free_found, st_found;
    logic [IW-1:0]    free_idx, st_idx;
    slot_t            head_e, st_sel;
    logic             ld_pop, ld_push, st_pop, st_push;

    lsq_hazard_matrix #(.DEPTH(DEPTH)) u_matrix (
        .ldq      (st_q.lq),
        .stq      (st_q.sq),
        .ld_block (ld_block),
        .st_block (st_block)
    );

    for (genvar gs = 0; gs < DEPTH; gs++) begin : g_stq
        assign st_free[gs] = !st_q.sq[gs].valid;
        assign st_elig[gs] = st_q.sq[gs].valid && st_q.sq[gs].addr_ok && !st_block[gs];
    end

    lsq_pick_first #(.N(DEPTH), .IW(IW)) u_free_pick (
        .req   (st_free),
        .found (free_found),
        .idx   (free_idx)
    );

    lsq_pick_first #(.N(DEPTH), .IW(IW)) u_issue_pick (
        .req   (st_elig),
        .found (st_found),
        .idx   (st_idx)
    );

    assign head_e = st_q.lq[st_q.ld_head];
    assign st_sel = st_q.sq[st_idx];

    assign ld_enq_ready   = (st_q.ld_count != CW'(DEPTH));
    assign ld_enq_slot    = st_q.ld_tail;
    assign st_enq_ready   = free_found;
    assign st_enq_slot    = free_idx;

    assign ld_issue_valid = head_e.valid && head_e.addr_ok && !ld_block[st_q.ld_head];
    assign ld_issue_slot  = st_q.ld_head;
    assign ld_issue_addr  = head_e.addr;
    assign ld_issue_tag   = head_e.tag;

    assign st_issue_valid = st_found;
    assign st_issue_slot  = st_idx;
    assign st_issue_addr  = st_sel.addr;
    assign st_issue_tag   = st_sel.tag;

    assign ld_hazard      = ld_block;
    assign st_hazard      = st_block;

    assign ld_pop  = ld_issue_valid && ld_issue_ready;
    assign ld_push = ld_enq_valid && ld_enq_ready;
    assign st_pop  = st_issue_valid && st_issue_ready;
    assign st_push = st_enq_valid && st_enq_ready;

    always_comb begin
        st_d = st_q;

        if (ld_upd_valid && st_q.lq[ld_upd_slot].valid) begin
            st_d.lq[ld_upd_slot].addr_ok = 1'b1;
            st_d.lq[ld_upd_slot].addr    = ld_upd_addr;
        end
        if (st_upd_valid && st_q.sq[st_upd_slot].valid) begin
            st_d.sq[st_upd_slot].addr_ok = 1'b1;
            st_d.sq[st_upd_slot].addr    = st_upd_addr;
        end

        if (ld_pop) begin
            st_d.lq[st_q.ld_head].valid = 1'b0;
            st_d.ld_head = bump(st_q.ld_head);
        end
        if (ld_push) begin
            st_d.lq[st_q.ld_tail] = '{valid: 1'b1, addr_ok: ld_enq_addr_valid,
                                      addr: ld_enq_addr, tag: ld_enq_tag};
            st_d.ld_tail = bump(st_q.ld_tail);
        end
        st_d.ld_count = st_q.ld_count + CW'(ld_push) - CW'(ld_pop);

        if (st_pop) begin
            st_d.sq[st_idx].valid = 1'b0;
        end
        if (st_push) begin
            st_d.sq[free_idx] = '{valid: 1'b1, addr_ok: st_enq_addr_valid,
                                  addr: st_enq_addr, tag: st_enq_tag};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lsq_order_check_sva.sv
module lsq_order_check_sva #(
    parameter int DEPTH = 4,
    parameter int IW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_enq_ready,
    input logic             ld_issue_valid,
    input logic             ld_issue_ready,
    input logic [IW-1:0]    ld_issue_slot,
    input logic             st_issue_valid,
    input logic [IW-1:0]    st_issue_slot,
    input logic [DEPTH-1:0] ld_hazard,
    input logic [DEPTH-1:0] st_hazard
);
    // R4: an offered load is never one flagged as blocked
    p_ld_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_issue_valid |-> !ld_hazard[ld_issue_slot]);

    // R6/R7: an offered store is never one flagged as blocked
    p_st_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_issue_valid |-> !st_hazard[st_issue_slot]);

    // R3: the head only moves when a load is taken
    p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_issue_valid && !ld_issue_ready) |=> $stable(ld_issue_slot));

    // R2: a full load queue only frees up through a dequeue
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_enq_ready |=> (!ld_enq_ready || $past(ld_issue_valid && ld_issue_ready)));

    // R12: the head moves only after a handshake
    p_head_move_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_issue_valid && ld_issue_ready) |=> $stable(ld_issue_slot));
endmodule

bind lsq_order_check lsq_order_check_sva #(.DEPTH(DEPTH), .IW(IW)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .ld_enq_ready   (ld_enq_ready),
    .ld_issue_valid (ld_issue_valid),
    .ld_issue_ready (ld_issue_ready),
    .ld_issue_slot  (ld_issue_slot),
    .st_issue_valid (st_issue_valid),
    .st_issue_slot  (st_issue_slot),
    .ld_hazard      (ld_hazard),
    .st_hazard      (st_hazard)
);

// File: tb/lsq_order_check_tb.sv
module lsq_order_check_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_enq_valid = 0, ld_enq_addr_valid = 0;
    logic [31:0] ld_enq_addr = 0;
    logic [3:0]  ld_enq_tag = 0;
    logic        ld_enq_ready;
    logic [1:0]  ld_enq_slot;
    logic        st_enq_valid = 0, st_enq_addr_valid = 0;
    logic [31:0] st_enq_addr = 0;
    logic [3:0]  st_enq_tag = 0;
    logic        st_enq_ready;
    logic [1:0]  st_enq_slot;
    logic        ld_upd_valid = 0;
    logic [1:0]  ld_upd_slot = 0;
    logic [31:0] ld_upd_addr = 0;
    logic        st_upd_valid = 0;
    logic [1:0]  st_upd_slot = 0;
    logic [31:0] st_upd_addr = 0;
    logic        ld_issue_valid, ld_issue_ready = 0;
    logic [1:0]  ld_issue_slot;
    logic [31:0] ld_issue_addr;
    logic [3:0]  ld_issue_tag;
    logic        st_issue_valid, st_issue_ready = 0;
    logic [1:0]  st_issue_slot;
    logic [31:0] st_issue_addr;
    logic [3:0]  st_issue_tag;
    logic [3:0]  ld_hazard, st_hazard;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsq_order_check u_dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic enq_ld(logic [31:0] a, logic av, logic [3:0] t);
        ld_enq_valid = 1; ld_enq_addr = a; ld_enq_addr_valid = av; ld_enq_tag = t;
        tick();
        ld_enq_valid = 0;
    endtask

    task automatic enq_st(logic [31:0] a, logic av, logic [3:0] t);
        st_enq_valid = 1; st_enq_addr = a; st_enq_addr_valid = av; st_enq_tag = t;
        tick();
        st_enq_valid = 0;
    endtask

    task automatic take_ld();
        ld_issue_ready = 1; tick(); ld_issue_ready = 0;
    endtask

    task automatic take_st();
        st_issue_ready = 1; tick(); st_issue_ready = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ld_enq_ready", ld_enq_ready, 1);
        chk("R1 st_enq_ready", st_enq_ready, 1);
        chk("R1 ld_issue_valid", ld_issue_valid, 0);
        chk("R1 st_issue_valid", st_issue_valid, 0);
        chk("R1 hazards", {ld_hazard, st_hazard}, 0);
        chk("R1 enq slots", {ld_enq_slot, st_enq_slot}, 0);
    endtask

    task automatic t_raw();
        do_reset();
        enq_st(32'h100, 1, 4'd0);
        enq_ld(32'h100, 1, 4'd1);
        chk("R4 ld_hazard", ld_hazard[0], 1);
        chk("R4 load held", ld_issue_valid, 0);
        chk("R4 store free", st_issue_valid, 1);
        take_st();
        chk("R4 load after store left", ld_issue_valid, 1);
        chk("R4 load tag", ld_issue_tag, 1);
        take_ld();
        chk("R12 load gone", ld_issue_valid, 0);
        chk("R12 tail moved", ld_enq_slot, 1);
    endtask

    task automatic t_unknown();
        do_reset();
        enq_st(32'h0, 0, 4'd0);
        enq_ld(32'h500, 1, 4'd1);
        chk("R5 unknown store blocks", ld_hazard[0], 1);
        chk("R5 load held", ld_issue_valid, 0);
        st_upd_valid = 1; st_upd_slot = 0; st_upd_addr = 32'h600;
        tick();
        st_upd_valid = 0;
        chk("R10 hazard cleared", ld_hazard[0], 0);
        chk("R10 load offered", ld_issue_valid, 1);
        chk("R10 store offered addr", st_issue_addr, 32'h600);
    endtask

    task automatic t_war();
        do_reset();
        enq_ld(32'h300, 1, 4'd0);
        enq_st(32'h303, 1, 4'd1);
        chk("R6 R8 store hazard same word", st_hazard[0], 1);
        chk("R6 store held", st_issue_valid, 0);
        chk("R6 load offered", ld_issue_valid, 1);
        take_ld();
        chk("R6 store after load left", st_issue_valid, 1);
        do_reset();
        enq_ld(32'h0, 0, 4'd0);
        enq_st(32'h900, 1, 4'd1);
        chk("R6 unknown load blocks store", st_hazard[0], 1);
    endtask

    task automatic t_waw();
        do_reset();
        enq_st(32'h400, 1, 4'd0);
        enq_st(32'h400, 1, 4'd1);
        enq_st(32'h404, 1, 4'd2);
        chk("R7 R8 hazard pattern", st_hazard, 4'b0010);
        chk("R11 lowest offered", st_issue_slot, 0);
        take_st();
        chk("R11 next lowest offered", st_issue_slot, 1);
        chk("R11 still valid", st_issue_valid, 1);
        take_st();
        chk("R11 last store", st_issue_slot, 2);
        chk("R11 lowest free slot", st_enq_slot, 0);
    endtask

    task automatic t_age();
        do_reset();
        enq_ld(32'h700, 1, 4'd5);
        enq_st(32'h700, 1, 4'd6);
        chk("R9 younger store ignored", ld_hazard[0], 0);
        chk("R9 load offered", ld_issue_valid, 1);
        do_reset();
        enq_ld(32'h700, 1, 4'd1);
        enq_st(32'h700, 1, 4'd15);
        chk("R9 wrapped tag older", ld_hazard[0], 1);
        chk("R9 wrapped store free", st_issue_valid, 1);
    endtask

    task automatic t_order();
        do_reset();
        enq_ld(32'h0, 0, 4'd1);
        enq_ld(32'h800, 1, 4'd2);
        chk("R3 ready younger waits", ld_issue_valid, 0);
        chk("R3 head slot", ld_issue_slot, 0);
        ld_upd_valid = 1; ld_upd_slot = 0; ld_upd_addr = 32'h840;
        tick();
        ld_upd_valid = 0;
        chk("R10 R3 head offered", ld_issue_tag, 1);
        chk("R10 head addr", ld_issue_addr, 32'h840);
        take_ld();
        chk("R3 second load", ld_issue_tag, 2);
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 0; k < 4; k++) enq_ld(32'h200 + 16*k, 1, k[3:0]);
        chk("R2 full", ld_enq_ready, 0);
        enq_ld(32'hA00, 1, 4'd9);
        for (int k = 0; k < 4; k++) begin
            chk("R2 R3 order", ld_issue_tag, k);
            take_ld();
        end
        chk("R2 dropped load absent", ld_issue_valid, 0);
        for (int k = 0; k < 4; k++) enq_st(32'h1000 + 16*k, 1, k[3:0]);
        chk("R11 store queue full", st_enq_ready, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_raw();
        t_unknown();
        t_war();
        t_waw();
        t_age();
        t_order();
        t_full();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule